// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide command and status interface of an eight-line interrupt controller. The address bit picks one of two ports. Writes to the command port either start initialisation, adjust read and poll behaviour, or issue end-of-service and priority-rotation commands. Writes to the data port carry the later words of the initialisation sequence, or load the mask once initialisation is complete. Reads return the request, in-service or mask register, or a poll result.

Priority resolution happens outside this block. The neighbouring resolver supplies two inputs: the pending line that would be granted, and the highest-priority line currently in service. Request and in-service bits are set through per-line pulse inputs, which come from the edge detector and the acknowledge logic. The block holds the line registers, the mode flags, the vector base and the rotation offset, and drives them out to the resolver and the vector builder.

Top module: `pic_cmd_port`

## Requirements
- R1: A write to port 0 (addr=0) with data bit 4 set starts initialisation. In the next cycle, request, in-service, mask, rotation offset, vector base and every mode flag read zero, `init_busy` is 1, and `int_clear` is high for exactly that one cycle.
- R2: The first port-1 (addr=1) write after an initialisation start sets `vector_base` to the data with its low three bits forced to zero.
- R3: The second port-1 write after an initialisation start changes no register. If bit 0 of the starting command was 1, a third port-1 write is awaited; otherwise `init_busy` falls.
- R4: The third port-1 write, when it is awaited, sets `fully_nested` from bit 4 and `auto_eoi` from bit 1, then ends initialisation. While `init_busy` is 0, every port-1 write loads `imr` with the data.
- R5: A port-0 write with bit 4 clear and bit 3 set is a read-control command. When bit 1 is set, bit 0 selects what port-0 reads return: in-service (1) or request (0). Port-1 reads always return `imr`.
- R6: In a read-control command, bit 6 set makes bit 5 the new `special_mask` value. Bit 6 clear leaves `special_mask` unchanged.
- R7: A port-0 write with bits 4 and 3 clear is a service command, and its code is data bits 7:5. Codes 0 and 4 set `rotate_auto_eoi` to code bit 2.
- R8: Code 1 clears the in-service bit named by `isr_top_line` when `isr_top_valid` is 1, and does nothing otherwise. Code 5 does the same and also sets `prio_offset` to that line plus 1, modulo 8.
- R9: Code 3 clears in-service bit data[2:0]. Code 7 clears the same bit and sets `prio_offset` to data[2:0] plus 1, modulo 8.
- R10: Code 6 sets `prio_offset` to data[2:0] plus 1, modulo 8, and leaves the in-service register alone.
- R11: Code 2 changes neither the in-service register nor `prio_offset`.
- R12: In a read-control command, bit 2 arms poll mode. The next read, on either port, returns {5'b0, `pend_line`} when `pend_valid` is 1 and 0 otherwise. That read clears the request and in-service bits of the returned line and disarms poll mode.
- R13: `rd_data` is registered. It is valid in the cycle after `rd_en` and holds its value until the next read. A 1 on `req_set[i]` or `isr_set[i]` sets the matching request or in-service bit in the next cycle, unless an initialisation starts in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 1 | Port select: 0 command, 1 data |
| wr_data | input | 8 | Write data |
| req_set | input | 8 | Per-line request set pulses |
| isr_set | input | 8 | Per-line in-service set pulses |
| pend_valid | input | 1 | Resolver has a pending line |
| pend_line | input | 3 | Resolver's pending line |
| isr_top_valid | input | 1 | At least one line is in service |
| isr_top_line | input | 3 | Highest-priority in-service line |
| rd_data | output | 8 | Registered read data |
| irr | output | 8 | Request register |
| isr | output | 8 | In-service register |
| imr | output | 8 | Mask register |
| vector_base | output | 8 | Vector base, low three bits zero |
| prio_offset | output | 3 | Rotation offset (lowest-numbered top priority line) |
| fully_nested | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end-of-service mode |
| rotate_auto_eoi | output | 1 | Rotate on automatic end-of-service |
| special_mask | output | 1 | Special mask mode |
| poll_armed | output | 1 | Poll mode armed for the next read |
| init_busy | output | 1 | Initialisation sequence in progress |
| int_clear | output | 1 | One-cycle pulse that withdraws the interrupt output |

## Verification
Several rules are checked by the assertions on every cycle:
- the full clear that follows an initialisation start, with its one-cycle interrupt-withdraw pulse;
- mask loads outside initialisation;
- the offset produced by code 6;
- the inertness of code 2;
- poll disarming after a read;
- the mask readback path;
- the request set pulses.

Other behaviour depends on sequence position or on resolver inputs, so only the bench's scenarios can show it:
- the word-count dependence of the initialisation sequence;
- the vector base masking;
- the mode bits of the fourth word;
- the non-specific end-of-service codes, which use `isr_top_line`;
- the poll value with and without a pending line.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

    localparam int LINES   = 8;
    localparam int LINE_W  = $clog2(LINES);
    localparam int DATA_W  = 8;

    // bit positions inside a command-port write
    localparam int B_INIT  = 4;
    localparam int B_RDCTL = 3;
    localparam int B_POLL  = 2;
    localparam int B_RSVAL = 1;
    localparam int B_SMEN  = 6;
    localparam int B_SMVAL = 5;

    typedef enum logic [1:0] {
        ST_READY     = 2'd0,
        ST_WANT_BASE = 2'd1,
        ST_WANT_SKIP = 2'd2,
        ST_WANT_MODE = 2'd3
    } init_state_e;

    typedef enum logic [2:0] {
        SC_ROT_OFF  = 3'd0,
        SC_EOI_TOP  = 3'd1,
        SC_NOP      = 3'd2,
        SC_EOI_LINE = 3'd3,
        SC_ROT_ON   = 3'd4,
        SC_EOI_ROT  = 3'd5,
        SC_SET_PRIO = 3'd6,
        SC_EOI_SETP = 3'd7
    } svc_code_e;

    typedef struct packed {
        logic       start_init;
        logic       data_wr;
        logic       read_ctl;
        logic       service;
        svc_code_e  code;
        logic [LINE_W-1:0] line;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    function automatic logic [LINE_W-1:0] line_after(input logic [LINE_W-1:0] l);
        return l + 1'b1;
    endfunction

endpackage

// File: rtl/pic_wr_decode.sv
module pic_wr_decode
    import pic_cmd_pkg::*;
(
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_cmd_t           cmd
);
    always_comb begin
        cmd            = '0;
        cmd.data       = wr_data;
        cmd.line       = wr_data[LINE_W-1:0];
        cmd.code       = svc_code_e'(wr_data[DATA_W-1:DATA_W-3]);
        cmd.data_wr    = wr_en && addr;
        cmd.start_init = wr_en && !addr && wr_data[B_INIT];
        cmd.read_ctl   = wr_en && !addr && !wr_data[B_INIT] && wr_data[B_RDCTL];
        cmd.service    = wr_en && !addr && !wr_data[B_INIT] && !wr_data[B_RDCTL];
    end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_init,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data,
    output logic              mask_load,
    output logic              busy,
    output logic [DATA_W-1:0] vector_base,
    output logic              fully_nested,
    output logic              auto_eoi
);
    init_state_e state;
    logic        want_mode;

    assign busy      = (state != ST_READY);
    assign mask_load = data_wr && (state == ST_READY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_READY;
            want_mode    <= 1'b0;
            vector_base  <= '0;
            fully_nested <= 1'b0;
            auto_eoi     <= 1'b0;
        end else if (start_init) begin
            state        <= ST_WANT_BASE;
            want_mode    <= data[0];
            vector_base  <= '0;
            fully_nested <= 1'b0;
            auto_eoi     <= 1'b0;
        end else if (data_wr) begin
            case (state)
                ST_WANT_BASE: begin
                    vector_base <= data & ~DATA_W'(LINES - 1);
                    state       <= ST_WANT_SKIP;
                end
                ST_WANT_SKIP: state <= want_mode ? ST_WANT_MODE : ST_READY;
                ST_WANT_MODE: begin
                    fully_nested <= data[4];
                    auto_eoi     <= data[1];
                    state        <= ST_READY;
                end
                default: state <= ST_READY;
            endcase
        end
    end
endmodule

// File: rtl/pic_ocw_flags.sv
module pic_ocw_flags
    import pic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_init,
    input  logic              read_ctl,
    input  logic              service,
    input  svc_code_e         code,
    input  logic [DATA_W-1:0] data,
    input  logic              poll_take,
    output logic              read_isr_sel,
    output logic              poll_armed,
    output logic              special_mask,
    output logic              rotate_auto_eoi
);
    always_ff @(posedge clk) begin
        if (rst || start_init) begin
            read_isr_sel    <= 1'b0;
            poll_armed      <= 1'b0;
            special_mask    <= 1'b0;
            rotate_auto_eoi <= 1'b0;
        end else begin
            if (poll_take)
                poll_armed <= 1'b0;
            if (read_ctl) begin
                if (data[B_POLL])
                    poll_armed <= 1'b1;
                if (data[B_RSVAL])
                    read_isr_sel <= data[0];
                if (data[B_SMEN])
                    special_mask <= data[B_SMVAL];
            end
            if (service && (code == SC_ROT_OFF || code == SC_ROT_ON))
                rotate_auto_eoi <= code[2];
        end
    end
endmodule

// File: rtl/pic_line_regs.sv
module pic_line_regs
    import pic_cmd_pkg::*;
#(
    parameter int N = LINES,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_init,
    input  logic          mask_load,
    input  logic          service,
    input  svc_code_e     code,
    input  logic [LW-1:0] line,
    input  logic [N-1:0]  data,
    input  logic          isr_top_valid,
    input  logic [LW-1:0] isr_top_line,
    input  logic          poll_take,
    input  logic          pend_valid,
    input  logic [LW-1:0] pend_line,
    input  logic [N-1:0]  req_set,
    input  logic [N-1:0]  isr_set,
    output logic [N-1:0]  irr,
    output logic [N-1:0]  isr,
    output logic [N-1:0]  imr,
    output logic [LW-1:0] prio_offset
);
    logic top_eoi, line_eoi;
    logic [N-1:0] irr_nx, isr_nx;
    logic [LW-1:0] off_nx;

    assign top_eoi  = service && isr_top_valid &&
                      (code == SC_EOI_TOP || code == SC_EOI_ROT);
    assign line_eoi = service && (code == SC_EOI_LINE || code == SC_EOI_SETP);

    for (genvar i = 0; i < N; i++) begin : g_line
        logic eoi_hit, poll_hit;
        assign eoi_hit  = (top_eoi && isr_top_line == LW'(i)) ||
                          (line_eoi && line == LW'(i));
        assign poll_hit = poll_take && pend_valid && pend_line == LW'(i);
        assign irr_nx[i] = (irr[i] && !poll_hit) || req_set[i];
        assign isr_nx[i] = (isr[i] && !eoi_hit && !poll_hit) || isr_set[i];
    end

    always_comb begin
        off_nx = prio_offset;
        if (service) begin
            case (code)
                SC_EOI_ROT:  if (isr_top_valid) off_nx = line_after(isr_top_line);
                SC_SET_PRIO: off_nx = line_after(line);
                SC_EOI_SETP: off_nx = line_after(line);
                default:     off_nx = prio_offset;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start_init) begin
            irr         <= '0;
            isr         <= '0;
            imr         <= '0;
            prio_offset <= '0;
        end else begin
            irr         <= irr_nx;
            isr         <= isr_nx;
            prio_offset <= off_nx;
            if (mask_load)
                imr <= data;
        end
    end
endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
    import pic_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LINES-1:0]  req_set,
    input  logic [LINES-1:0]  isr_set,
    input  logic              pend_valid,
    input  logic [LINE_W-1:0] pend_line,
    input  logic              isr_top_valid,
    input  logic [LINE_W-1:0] isr_top_line,
    output logic [DATA_W-1:0] rd_data,
    output logic [LINES-1:0]  irr,
    output logic [LINES-1:0]  isr,
    output logic [LINES-1:0]  imr,
    output logic [DATA_W-1:0] vector_base,
    output logic [LINE_W-1:0] prio_offset,
    output logic              fully_nested,
    output logic              auto_eoi,
    output logic              rotate_auto_eoi,
    output logic              special_mask,
    output logic              poll_armed,
    output logic              init_busy,
    output logic              int_clear
);
    wr_cmd_t cmd;
    logic    mask_load;
    logic    read_isr_sel;
    logic    poll_take;
    logic [DATA_W-1:0] rd_next;

    assign poll_take = rd_en && poll_armed;

    pic_wr_decode u_dec (
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    pic_init_seq u_init (
        .clk          (clk),
        .rst          (rst),
        .start_init   (cmd.start_init),
        .data_wr      (cmd.data_wr),
        .data         (cmd.data),
        .mask_load    (mask_load),
        .busy         (init_busy),
        .vector_base  (vector_base),
        .fully_nested (fully_nested),
        .auto_eoi     (auto_eoi)
    );

    pic_ocw_flags u_flags (
        .clk             (clk),
        .rst             (rst),
        .start_init      (cmd.start_init),
        .read_ctl        (cmd.read_ctl),
        .service         (cmd.service),
        .code            (cmd.code),
        .data            (cmd.data),
        .poll_take       (poll_take),
        .read_isr_sel    (read_isr_sel),
        .poll_armed      (poll_armed),
        .special_mask    (special_mask),
        .rotate_auto_eoi (rotate_auto_eoi)
    );

    pic_line_regs #(.N(LINES)) u_lines (
        .clk           (clk),
        .rst           (rst),
        .start_init    (cmd.start_init),
        .mask_load     (mask_load),
        .service       (cmd.service),
        .code          (cmd.code),
        .line          (cmd.line),
        .data          (cmd.data),
        .isr_top_valid (isr_top_valid),
        .isr_top_line  (isr_top_line),
        .poll_take     (poll_take),
        .pend_valid    (pend_valid),
        .pend_line     (pend_line),
        .req_set       (req_set),
        .isr_set       (isr_set),
        .irr           (irr),
        .isr           (isr),
        .imr           (imr),
        .prio_offset   (prio_offset)
    );

    always_comb begin
        if (poll_armed)
            rd_next = pend_valid ? DATA_W'(pend_line) : '0;
        else if (addr)
            rd_next = imr;
        else
            rd_next = read_isr_sel ? isr : irr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            int_clear <= 1'b0;
        end else begin
            int_clear <= cmd.start_init;
            if (rd_en)
                rd_data <= rd_next;
        end
    end
endmodule

// File: rtl/pic_cmd_port_chk.sv
module pic_cmd_port_chk
    import pic_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [LINES-1:0]  req_set,
    input logic [DATA_W-1:0] rd_data,
    input logic [LINES-1:0]  irr,
    input logic [LINES-1:0]  isr,
    input logic [LINES-1:0]  imr,
    input logic [LINE_W-1:0] prio_offset,
    input logic              poll_armed,
    input logic              init_busy,
    input logic              int_clear
);
    logic init_wr, svc_wr;
    assign init_wr = wr_en && !addr && wr_data[B_INIT];
    assign svc_wr  = wr_en && !addr && !wr_data[B_INIT] && !wr_data[B_RDCTL];

    assert_init_clear_R1: assert property (@(posedge clk) disable iff (rst)
        init_wr |=> (irr == '0 && isr == '0 && imr == '0 && prio_offset == '0 &&
                     int_clear && init_busy && !poll_armed));

    assert_int_clear_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        (int_clear && !$past(init_wr)) |-> 1'b0);

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr && !init_busy) |=> imr == $past(wr_data));

    assert_mask_read_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr && !poll_armed) |=> rd_data == $past(imr));

    assert_set_prio_R10: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && wr_data[7:5] == 3'd6) |=> prio_offset == $past(wr_data[2:0]) + 3'd1);

    assert_nop_code_R11: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && wr_data[7:5] == 3'd2) |=> $stable(prio_offset));

    assert_poll_disarm_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_en && poll_armed && !wr_en) |=> !poll_armed);

    assert_req_set_R13: assert property (@(posedge clk) disable iff (rst)
        (!init_wr) |=> ((irr & $past(req_set)) == $past(req_set)));
endmodule

bind pic_cmd_port pic_cmd_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wr_data     (wr_data),
    .req_set     (req_set),
    .rd_data     (rd_data),
    .irr         (irr),
    .isr         (isr),
    .imr         (imr),
    .prio_offset (prio_offset),
    .poll_armed  (poll_armed),
    .init_busy   (init_busy),
    .int_clear   (int_clear)
);

// File: tb/sim_pic_cmd_port.sv
module sim_pic_cmd_port;
    import pic_cmd_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
    logic [7:0] wr_data = '0, req_set = '0, isr_set = '0;
    logic pend_valid = 1'b0, isr_top_valid = 1'b0;
    logic [2:0] pend_line = '0, isr_top_line = '0;
    logic [7:0] rd_data, irr, isr, imr, vector_base;
    logic [2:0] prio_offset;
    logic fully_nested, auto_eoi, rotate_auto_eoi, special_mask, poll_armed, init_busy, int_clear;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    pic_cmd_port u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .req_set(req_set), .isr_set(isr_set),
        .pend_valid(pend_valid), .pend_line(pend_line),
        .isr_top_valid(isr_top_valid), .isr_top_line(isr_top_line),
        .rd_data(rd_data), .irr(irr), .isr(isr), .imr(imr),
        .vector_base(vector_base), .prio_offset(prio_offset),
        .fully_nested(fully_nested), .auto_eoi(auto_eoi),
        .rotate_auto_eoi(rotate_auto_eoi), .special_mask(special_mask),
        .poll_armed(poll_armed), .init_busy(init_busy), .int_clear(int_clear)
    );

    // {addr, data, selector, expected}; selector 1 imr, 2 base, 3 offset, 4 isr, 5 flags
    localparam int NV = 10;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 8'h11, 3'd5, 8'h41},   // R1 init start, fourth word wanted
        {1'b1, 8'h6D, 3'd2, 8'h68},   // R2 base masked
        {1'b1, 8'h55, 3'd5, 8'h40},   // R3 third word ignored, still busy
        {1'b1, 8'h12, 3'd5, 8'h06},   // R4 nested + auto eoi, done
        {1'b1, 8'hA5, 3'd1, 8'hA5},   // R4 mask load
        {1'b0, 8'h68, 3'd5, 8'h16},   // R6 special mask on
        {1'b0, 8'h80, 3'd5, 8'h1E},   // R7 code 4 rotate on
        {1'b0, 8'h00, 3'd5, 8'h16},   // R7 code 0 rotate off
        {1'b0, 8'hC3, 3'd3, 8'h04},   // R10 offset line 3 + 1
        {1'b0, 8'hC7, 3'd3, 8'h00}    // R10 offset wraps
    };

    function automatic logic [7:0] flags();
        return {1'b0, init_busy, poll_armed, special_mask, rotate_auto_eoi,
                auto_eoi, fully_nested, int_clear};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_sets(input logic [7:0] r, input logic [7:0] s);
        @(negedge clk);
        req_set = r; isr_set = s;
        @(negedge clk);
        req_set = '0; isr_set = '0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset flags", flags(), 8'h00);
        check("R1 reset imr", imr, 8'h00);
        check("R13 reset rd_data", rd_data, 8'h00);

        for (int k = 0; k < NV; k++) begin
            logic [19:0] v;
            logic [7:0]  act;
            v = VEC[k];
            wr(v[19], v[18:11]);
            case (v[10:8])
                3'd1:    act = imr;
                3'd2:    act = vector_base;
                3'd3:    act = {5'b0, prio_offset};
                3'd4:    act = isr;
                default: act = flags();
            endcase
            check($sformatf("table row %0d (R1..R10)", k), act, v[7:0]);
        end

        pulse_sets(8'h00, 8'hFF);
        check("R13 isr set", isr, 8'hFF);
        wr(1'b0, 8'h65);
        check("R9 code 3 clears line 5", isr, 8'hDF);
        wr(1'b0, 8'hE1);
        check("R9 code 7 clears line 1", isr, 8'hDD);
        check("R9 code 7 offset", {5'b0, prio_offset}, 8'h02);
        isr_top_valid = 1'b1; isr_top_line = 3'd3;
        wr(1'b0, 8'h20);
        check("R8 code 1 clears top", isr, 8'hD5);
        isr_top_line = 3'd7;
        wr(1'b0, 8'hA0);
        check("R8 code 5 clears top", isr, 8'h55);
        check("R8 code 5 offset", {5'b0, prio_offset}, 8'h00);
        isr_top_valid = 1'b0;
        wr(1'b0, 8'h20);
        check("R8 code 1 without top", isr, 8'h55);
        wr(1'b0, 8'hC4);
        wr(1'b0, 8'h40);
        check("R11 code 2 isr", isr, 8'h55);
        check("R11 code 2 offset", {5'b0, prio_offset}, 8'h05);

        pulse_sets(8'h81, 8'h00);
        check("R13 irr set", irr, 8'h81);
        rd(1'b0);
        check("R5 read request", rd_data, 8'h81);
        wr(1'b0, 8'h0B);
        rd(1'b0);
        check("R5 read in-service", rd_data, 8'h55);
        wr(1'b0, 8'h0A);
        rd(1'b0);
        check("R5 read request again", rd_data, 8'h81);
        rd(1'b1);
        check("R5 read mask", rd_data, 8'hA5);
        @(negedge clk);
        check("R13 rd_data holds", rd_data, 8'hA5);

        pulse_sets(8'h20, 8'h20);
        pend_valid = 1'b1; pend_line = 3'd5;
        wr(1'b0, 8'h0C);
        check("R12 poll armed", {7'b0, poll_armed}, 8'h01);
        rd(1'b0);
        check("R12 poll value", rd_data, 8'h05);
        check("R12 poll clears irr", irr, 8'h81);
        check("R12 poll clears isr", isr, 8'h55);
        check("R12 poll disarmed", {7'b0, poll_armed}, 8'h00);
        pend_valid = 1'b0;
        wr(1'b0, 8'h0C);
        rd(1'b1);
        check("R12 poll none", rd_data, 8'h00);
        check("R12 poll none irr", irr, 8'h81);

        wr(1'b0, 8'h10);
        check("R1 init clears irr", irr, 8'h00);
        check("R1 init clears isr", isr, 8'h00);
        check("R1 init clears mask", imr, 8'h00);
        wr(1'b1, 8'h27);
        check("R2 base", vector_base, 8'h20);
        wr(1'b1, 8'hFF);
        check("R3 no fourth word", flags(), 8'h00);
        wr(1'b1, 8'h3C);
        check("R4 mask after short init", imr, 8'h3C);
        check("R3 flags after short init", flags(), 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule